// File: doc/BRIEF.md
# Asynchronous HDLC Transmit Framer

This block turns raw frame payload into the octet stream that an 8N1 UART transmitter sends on an asynchronous HDLC link. Upstream logic hands it payload bytes one at a time over a valid/ready handshake. The payload already holds the address and control fields, because the framer adds none of its own. The last byte is marked. The framer puts an opening flag in front of the payload. It runs a 16-bit CRC-CCITT over the payload octets as they were given, before any escaping. After the last payload octet it appends the ones-complemented check value, then a closing flag.

Transparency is applied to the outgoing stream after the CRC has been computed. Flag and escape octets are always escaped. A control octet below 0x20 is escaped when its bit is set in a 32-bit map input. The same rules apply to the two check-value octets. An escaped octet goes out as the escape octet followed by the original XOR 0x20.

The UART side presents the current octet on `txByte` and pulses `txTake` when it loads that octet. While no frame is in progress, the framer offers the idle character 0xFF. An abort request sent during a frame closes the frame at once with an abort sequence, and the framer then drops the remaining payload until the end of the frame.

Top module: `ahdlc_tx_framer`

## Requirements
- R1: After reset `txByte` is 0xFF, `txValid` is 1 and `inReady` is 0.
- R2: While no frame is pending, the idle octet 0xFF is presented with `inReady` low. When `inValid` rises in idle, the next cycle presents the opening flag 0x7E. Each frame starts with its own opening flag.
- R3: After the last payload octet, the framer sends the check value and then the closing flag 0x7E. The check value is computed over the unescaped payload with the reflected polynomial 0x8408 and initial value 0xFFFF. It is ones-complemented and sent low byte first.
- R4: A payload octet equal to 0x7E or 0x7D is sent as 0x7D followed by the octet XOR 0x20.
- R5: An octet v below 0x20 is escaped the same way when bit v of `ctrlEscMap` is 1, and sent unchanged when that bit is 0. The check-value octets follow the R4 and R5 rules too.
- R6: A payload byte is accepted in a cycle with `inValid` and `inReady` both high. `inReady` is high in three cases: in the cycle the opening flag is taken, in the cycle the final part of a non-last payload octet is taken, and while waiting for the next byte.
- R7: Payload bytes are sent in the order received, with nothing inserted. If the next payload byte is late inside a frame, `txValid` is 0 until that byte arrives.
- R8: `abortReq` can arrive anywhere from the opening flag through the check value, or while waiting for a byte. The next presented octets are then 0x7D and 0x7E. In that cycle `inReady` is 0, even if `txTake` is high. Afterwards the framer discards bytes until one marked last is accepted, presenting 0xFF meanwhile. No discarding is done if the last byte was already accepted.
- R9: `abortReq` has no effect in idle, during the closing flag, or during an abort sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrlEscMap | input | 32 | Bit v set: control octet v is escaped |
| inByte | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte present |
| inLast | input | 1 | Payload byte is the frame's last |
| inReady | output | 1 | Framer accepts the payload byte this cycle |
| abortReq | input | 1 | Abort the frame in progress |
| txByte | output | 8 | Octet offered to the UART |
| txValid | output | 1 | `txByte` is meaningful (0 only while a frame waits for payload) |
| txTake | input | 1 | UART loads `txByte` this cycle |

## Verification
An abort request can land in the same cycle that the UART takes an octet, and that same take may be the one that opens the slot for the next payload byte. The bench provokes this collision by placing aborts at varied offsets into frames while the UART takes octets on every cycle or at random. It judges the result cycle by cycle against a queue-based model: the abort must win, `inReady` must stay low, and no byte may be swallowed. A second overlap occurs when escaping and the check value meet: with every control octet mapped, an escaped check-value octet must still follow the complete payload in the correct order.

// File: rtl/ahdlc_tx_pkg.sv
package ahdlc_tx_pkg;
  localparam int OCT_W = 8;
  localparam logic [OCT_W-1:0] FLAG_OCT  = 8'h7E;
  localparam logic [OCT_W-1:0] ESC_OCT   = 8'h7D;
  localparam logic [OCT_W-1:0] FLIP_MASK = 8'h20;

  typedef enum logic [3:0] {
    PH_IDLE, PH_OPEN, PH_DATA, PH_GAP, PH_FCSLO, PH_FCSHI,
    PH_CLOSE, PH_ABESC, PH_ABFLAG, PH_DRAIN
  } phase_t;

  typedef enum logic [1:0] {SEL_IDLE, SEL_FLAG, SEL_ESC, SEL_CUR} sel_t;

  typedef struct packed {
    logic crcInit;
    logic loadIn;
    logic loadFcsLo;
    logic loadFcsHi;
    logic setEsc;
    sel_t sel;
  } ctl_stb_t;
endpackage

// File: rtl/ahdlc_tx_datapath.sv
module ahdlc_tx_datapath
  import ahdlc_tx_pkg::*;
#(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  parameter logic [OCT_W-1:0] IDLE_OCT = 8'hFF,
  parameter int MAP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_stb_t         stb,
  input  logic [OCT_W-1:0] inByte,
  input  logic             inLast,
  input  logic [MAP_W-1:0] ctrlEscMap,
  output logic [OCT_W-1:0] txByte,
  output logic             needEsc,
  output logic             escDone,
  output logic             lastHeld
);
  localparam int MAP_IDX_W = $clog2(MAP_W);

  logic [CRC_W-1:0] crcReg;
  logic [OCT_W-1:0] curByte;
  logic [CRC_W-1:0] fcsVal;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [OCT_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < OCT_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign fcsVal = ~crcReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crcReg   <= CRC_INIT;
      curByte  <= IDLE_OCT;
      escDone  <= 1'b0;
      lastHeld <= 1'b0;
    end else begin
      if (stb.crcInit) begin
        crcReg   <= CRC_INIT;
        lastHeld <= 1'b0;
      end
      if (stb.loadIn) begin
        crcReg   <= crcByte(crcReg, inByte);
        curByte  <= inByte;
        lastHeld <= inLast;
      end
      if (stb.loadFcsLo) curByte <= fcsVal[OCT_W-1:0];
      if (stb.loadFcsHi) curByte <= fcsVal[CRC_W-1:OCT_W];
      if (stb.loadIn || stb.loadFcsLo || stb.loadFcsHi) escDone <= 1'b0;
      else if (stb.setEsc)                              escDone <= 1'b1;
    end
  end

  always_comb begin
    needEsc = (curByte == FLAG_OCT) || (curByte == ESC_OCT) ||
              ((curByte < OCT_W'(MAP_W)) && ctrlEscMap[curByte[MAP_IDX_W-1:0]]);
    unique case (stb.sel)
      SEL_IDLE: txByte = IDLE_OCT;
      SEL_FLAG: txByte = FLAG_OCT;
      SEL_ESC:  txByte = ESC_OCT;
      default:  txByte = !needEsc ? curByte : (escDone ? (curByte ^ FLIP_MASK) : ESC_OCT);
    endcase
  end
endmodule

// File: rtl/ahdlc_tx_control.sv
module ahdlc_tx_control
  import ahdlc_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     txTake,
  input  logic     abortReq,
  input  logic     needEsc,
  input  logic     escDone,
  input  logic     lastHeld,
  output ctl_stb_t stb,
  output logic     inReady,
  output logic     txValid,
  output phase_t   phase
);
  phase_t nxt;
  logic byteDone, inFrame, abortHit, slot, accept, escFirst;

  always_comb begin
    byteDone = txTake && (!needEsc || escDone);
    escFirst = txTake && needEsc && !escDone;
    inFrame  = phase inside {PH_OPEN, PH_DATA, PH_GAP, PH_FCSLO, PH_FCSHI};
    abortHit = abortReq && inFrame;
    slot     = ((phase == PH_OPEN) && txTake) ||
               ((phase == PH_DATA) && byteDone && !lastHeld) ||
               (phase == PH_GAP) || (phase == PH_DRAIN);
    inReady  = slot && !abortHit;
    accept   = inReady && inValid;
    txValid  = (phase != PH_GAP);

    stb = '0;
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (inValid) begin nxt = PH_OPEN; stb.crcInit = 1'b1; end
      PH_OPEN: if (txTake) begin
        nxt = accept ? PH_DATA : PH_GAP;
        stb.loadIn = accept;
      end
      PH_GAP: if (accept) begin nxt = PH_DATA; stb.loadIn = 1'b1; end
      PH_DATA: begin
        stb.setEsc = escFirst;
        if (byteDone) begin
          if (lastHeld) begin nxt = PH_FCSLO; stb.loadFcsLo = 1'b1; end
          else begin
            nxt = accept ? PH_DATA : PH_GAP;
            stb.loadIn = accept;
          end
        end
      end
      PH_FCSLO: begin
        stb.setEsc = escFirst;
        if (byteDone) begin nxt = PH_FCSHI; stb.loadFcsHi = 1'b1; end
      end
      PH_FCSHI: begin
        stb.setEsc = escFirst;
        if (byteDone) nxt = PH_CLOSE;
      end
      PH_CLOSE:  if (txTake) nxt = PH_IDLE;
      PH_ABESC:  if (txTake) nxt = PH_ABFLAG;
      PH_ABFLAG: if (txTake) nxt = lastHeld ? PH_IDLE : PH_DRAIN;
      PH_DRAIN:  if (accept && inLast) nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase

    if (abortHit) begin
      nxt = PH_ABESC;
      stb.loadIn    = 1'b0;
      stb.loadFcsLo = 1'b0;
      stb.loadFcsHi = 1'b0;
      stb.setEsc    = 1'b0;
    end

    unique case (phase)
      PH_OPEN, PH_CLOSE, PH_ABFLAG:  stb.sel = SEL_FLAG;
      PH_ABESC:                      stb.sel = SEL_ESC;
      PH_DATA, PH_FCSLO, PH_FCSHI:   stb.sel = SEL_CUR;
      default:                       stb.sel = SEL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/ahdlc_tx_framer.sv
module ahdlc_tx_framer
  import ahdlc_tx_pkg::*;
#(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  parameter logic [7:0] IDLE_OCT = 8'hFF,
  parameter int MAP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAP_W-1:0] ctrlEscMap,
  input  logic [7:0]       inByte,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  input  logic             abortReq,
  output logic [7:0]       txByte,
  output logic             txValid,
  input  logic             txTake
);
  ctl_stb_t stb;
  phase_t   ctlPhase;
  logic     needEsc, escDone, lastHeld;

  ahdlc_tx_control u_ctl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inLast(inLast),
    .txTake(txTake), .abortReq(abortReq), .needEsc(needEsc),
    .escDone(escDone), .lastHeld(lastHeld), .stb(stb),
    .inReady(inReady), .txValid(txValid), .phase(ctlPhase)
  );

  ahdlc_tx_datapath #(
    .CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT),
    .IDLE_OCT(IDLE_OCT), .MAP_W(MAP_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .inByte(inByte), .inLast(inLast),
    .ctrlEscMap(ctrlEscMap), .txByte(txByte), .needEsc(needEsc),
    .escDone(escDone), .lastHeld(lastHeld)
  );
endmodule

// File: rtl/ahdlc_tx_checker.sv
module ahdlc_tx_checker
  import ahdlc_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input phase_t     phase,
  input logic       abortReq,
  input logic       inValid,
  input logic       inReady,
  input logic       txValid,
  input logic       txTake,
  input logic [7:0] txByte
);
  logic inFrame;
  assign inFrame = phase inside {PH_OPEN, PH_DATA, PH_GAP, PH_FCSLO, PH_FCSHI};

  assert_idle_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (txByte == 8'hFF && txValid && !inReady));

  assert_open_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && inValid) |=> (txByte == 8'h7E && txValid));

  assert_esc_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txTake && txByte == 8'h7D && !abortReq && phase inside {PH_DATA, PH_FCSLO, PH_FCSHI})
    |=> (txByte == 8'h5E || txByte == 8'h5D || txByte[7:5] == 3'b001));

  assert_gap_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!txValid && !abortReq) |-> inReady);

  assert_abort_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abortReq && inFrame) |=> (txByte == 8'h7D && txValid));

  assert_abort_noready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abortReq && inFrame) |-> !inReady);
endmodule

bind ahdlc_tx_framer ahdlc_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .phase(ctlPhase), .abortReq(abortReq),
  .inValid(inValid), .inReady(inReady), .txValid(txValid),
  .txTake(txTake), .txByte(txByte)
);

// File: tb/sim_ahdlc_tx_framer.sv
module sim_ahdlc_tx_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ctrlEscMap = '0;
  logic [7:0] inByte = '0;
  logic inValid = 1'b0, inLast = 1'b0, abortReq = 1'b0, txTake = 1'b0;
  logic inReady, txValid;
  logic [7:0] txByte;

  always #5 clk = ~clk;

  ahdlc_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .ctrlEscMap(ctrlEscMap), .inByte(inByte),
    .inValid(inValid), .inLast(inLast), .inReady(inReady), .abortReq(abortReq),
    .txByte(txByte), .txValid(txValid), .txTake(txTake)
  );

  int errs = 0, checks = 0, cyc = 0;
  int takeMode = 0, abortCycle = -10;
  bit gapMode = 0, expectAb = 0;
  string curTag = "R1";
  logic [7:0] srcB[$];
  bit srcL[$];
  logic [7:0] gotQ[$];

  // reference model: 0 idle, 1 frame, 2 abort sequence, 3 drain
  int mMode = 0;
  logic [7:0] mQ[$];
  logic [15:0] mCrc;
  bit mEnded = 0, mDrain = 0;
  bit expValid, expReady;
  logic [7:0] expByte;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [15:0] crcUpd(logic [15:0] c, logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  function automatic void pushEsc(logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D || (b < 8'h20 && ctrlEscMap[b[4:0]])) begin
      mQ.push_back(8'h7D);
      mQ.push_back(b ^ 8'h20);
    end else mQ.push_back(b);
  endfunction

  function automatic void modelOut();
    bit abortable = !(mEnded && mQ.size() == 1);
    expValid = 1'b1; expByte = 8'hFF; expReady = 1'b0;
    case (mMode)
      1: begin
        if (mQ.size() > 0) expByte = mQ[0]; else expValid = 1'b0;
        expReady = !mEnded && (mQ.size() == 0 || (mQ.size() == 1 && txTake))
                   && !(abortReq && abortable);
      end
      2: expByte = mQ[0];
      3: expReady = 1'b1;
      default: ;
    endcase
  endfunction

  function automatic void modelStep();
    bit acc = expReady && inValid;
    case (mMode)
      0: if (inValid) begin
        mQ = {8'h7E}; mCrc = 16'hFFFF; mEnded = 0; mMode = 1;
      end
      1: begin
        if (abortReq && !(mEnded && mQ.size() == 1)) begin
          mQ = {8'h7D, 8'h7E}; mDrain = !mEnded; mMode = 2;
        end else begin
          if (txTake && mQ.size() > 0) void'(mQ.pop_front());
          if (acc) begin
            mCrc = crcUpd(mCrc, inByte);
            pushEsc(inByte);
            if (inLast) begin
              mEnded = 1;
              pushEsc(~mCrc[7:0]);
              pushEsc(~mCrc[15:8]);
              mQ.push_back(8'h7E);
            end
          end
          if (mEnded && mQ.size() == 0) mMode = 0;
        end
      end
      2: begin
        if (txTake) void'(mQ.pop_front());
        if (mQ.size() == 0) mMode = mDrain ? 3 : 0;
      end
      3: if (inValid && inLast) mMode = 0;
      default: mMode = 0;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    case (takeMode)
      0: txTake = 1'b1;
      1: txTake = 1'($urandom_range(0, 1));
      default: txTake = (cyc % 3 == 0);
    endcase
    inValid = (srcB.size() > 0) && !(gapMode && $urandom_range(0, 2) == 0);
    inByte  = inValid ? srcB[0] : 8'h00;
    inLast  = inValid ? srcL[0] : 1'b0;
    abortReq = (cyc == abortCycle);
    #1;
    modelOut();
    check(txValid === expValid, curTag, 32'(txValid), 32'(expValid));
    if (expValid) check(txByte === expByte, curTag, 32'(txByte), 32'(expByte));
    check(inReady === expReady, curTag, 32'(inReady), 32'(expReady));
    if (expectAb && cyc == abortCycle + 1) check(txByte === 8'h7D, "R8", 32'(txByte), 32'h7D);
    if (expectAb && cyc == abortCycle + 2) check(txByte === 8'h7E, "R8", 32'(txByte), 32'h7E);
    if (txTake && txValid && txByte != 8'hFF) gotQ.push_back(txByte);
    @(posedge clk);
    modelStep();
    if (expReady && inValid) begin
      void'(srcB.pop_front());
      void'(srcL.pop_front());
    end
    cyc++;
  endtask

  task automatic addFrame(int len, int maxVal);
    for (int i = 0; i < len; i++) begin
      srcB.push_back(8'($urandom_range(0, maxVal)));
      srcL.push_back(i == len - 1);
    end
  endtask

  task automatic runIdle();
    for (int i = 0; i < 3000; i++) begin
      if (mMode == 0 && srcB.size() == 0) break;
      step();
    end
    step(); step();
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] vec[$];
    logic [7:0] escExp[$];
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txByte === 8'hFF, "R1", 32'(txByte), 32'hFF);
    check(txValid === 1'b1, "R1", 32'(txValid), 1);
    check(inReady === 1'b0, "R1", 32'(inReady), 0);

    curTag = "R2";
    repeat (5) step();

    // R3 known check value, R7 verbatim order
    curTag = "R3";
    for (int i = 0; i < 9; i++) begin
      srcB.push_back(8'h31 + 8'(i)); srcL.push_back(i == 8);
    end
    gotQ.delete();
    runIdle();
    vec = {8'h7E, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39,
           8'h6E, 8'h90, 8'h7E};
    check(gotQ.size() == vec.size(), "R3", 32'(gotQ.size()), 32'(vec.size()));
    for (int i = 0; i < vec.size() && i < gotQ.size(); i++)
      check(gotQ[i] === vec[i], (i >= 1 && i <= 9) ? "R7" : "R3", 32'(gotQ[i]), 32'(vec[i]));

    // R4 R5 escaping with a selective map
    curTag = "R4";
    ctrlEscMap = 32'h0000_0020;
    takeMode = 1;
    srcB = {8'h7E, 8'h7D, 8'h11, 8'h05, 8'h41};
    srcL = {1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    gotQ.delete();
    runIdle();
    escExp = {8'h7E, 8'h7E ^ 8'h00, 8'h5E, 8'h7D, 8'h5D, 8'h11, 8'h7D, 8'h25, 8'h41};
    escExp[1] = 8'h7D;
    for (int i = 0; i < escExp.size() && i < gotQ.size(); i++)
      check(gotQ[i] === escExp[i], (i == 5 || i == 7) ? "R5" : "R4", 32'(gotQ[i]), 32'(escExp[i]));

    // R5 all control octets mapped, FCS octets likely escaped
    curTag = "R5";
    ctrlEscMap = 32'hFFFF_FFFF;
    takeMode = 2;
    for (int f = 0; f < 20; f++) begin addFrame(1 + f % 6, 8'h3F); runIdle(); end

    // R6 R7 random takes and payload gaps
    curTag = "R6 R7";
    ctrlEscMap = 32'h000A_0001;
    takeMode = 1; gapMode = 1;
    for (int f = 0; f < 12; f++) begin addFrame(1 + f % 8, 8'hFF); runIdle(); end
    gapMode = 0;

    // R8 abort in data with drain, full-rate takes
    curTag = "R8";
    takeMode = 0; expectAb = 1;
    addFrame(10, 8'hFF);
    abortCycle = cyc + 6;
    runIdle();
    // abort while the opening flag is presented
    addFrame(6, 8'hFF);
    abortCycle = cyc + 1;
    runIdle();
    // abort during check value: last byte already taken, no drain
    addFrame(3, 8'h7F);
    abortCycle = cyc + 5;
    runIdle();
    expectAb = 0;
    // aborts at random offsets with random takes
    takeMode = 1;
    for (int f = 0; f < 10; f++) begin
      addFrame(4 + f % 5, 8'hFF);
      abortCycle = cyc + 1 + 2 * f;
      runIdle();
    end

    // R9 abort in idle and at closing flag ignored
    curTag = "R9";
    takeMode = 0;
    abortCycle = cyc + 1;
    repeat (4) step();
    addFrame(3, 8'h7F);
    abortCycle = cyc + 7;
    gotQ.delete();
    runIdle();
    check(gotQ.size() >= 7, "R9", 32'(gotQ.size()), 7);
    if (gotQ.size() > 0)
      check(gotQ[gotQ.size()-1] === 8'h7E, "R9", 32'(gotQ[gotQ.size()-1]), 32'h7E);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule